// File: doc/BRIEF.md
# I2C Command Pointer with Auto-Increment

This block holds the command register and register pointer of an I/O-port register file behind an I2C slave. An I2C front end does the bit-level work and passes decoded byte events to it: an address event that carries the transfer direction, a data-byte event, and a stop event. In a write transfer the first data byte is the command. The block checks that byte against a fixed set of legal codes and decides whether to ACK it. If it is legal, the byte is latched. Later write bytes go to the register the pointer selects, unless that register is one of the read-only input registers. In a read transfer each byte the front end asks for produces a read strobe at the current pointer.

Bit 7 of the command is the auto-increment flag and bits 5:0 are the pointer. With auto-increment on, the pointer steps after every data byte. For the banked registers it wraps inside its own group of banks; for the single registers it wraps inside that group of singles. A stop or repeated start never clears the command register, so a read issued without a fresh command continues from the stored pointer.

The byte event input is one event per cycle. There is no back-pressure: the block accepts an event in every cycle where `in_valid` is high. The results are registered and appear exactly one cycle after the event.

Top module: `i2c_cmd_pointer`

## Requirements
- R1: After reset the command register holds 0x80 (auto-increment on, pointer 0), so a read with no command strobes addresses 0, 1, 2 in turn.
- R2: The first data byte after a write-direction address event is the command, and it is ACKed only when its low 7 bits are one of 28 legal codes: 0x00-0x04 (input), 0x08-0x0C, 0x10-0x14, 0x18-0x1C, 0x20-0x24 (writable banked groups), and 0x28, 0x29, 0x2A (single registers); bit 7 plays no part in this check.
- R3: A NACKed command byte leaves the command register unchanged, and every later data byte in that transfer is NACKed with no strobe.
- R4: An ACKed command byte is latched whole: bits 5:0 become the pointer and bit 7 becomes the auto-increment flag.
- R5: A write data byte aimed at a writable register is ACKed and raises `wr_stb` with `acc_addr` equal to the pointer and `wr_data` equal to the byte.
- R6: A write data byte aimed at an input register (0x00-0x04) is NACKed and raises no write strobe.
- R7: With auto-increment on, the pointer advances after each data byte, whether read, written or NACKed. In a banked group it goes from bank 4 back to bank 0 of the same group (for example 0x0C to 0x08); among the single registers it goes from 0x2A back to 0x28.
- R8: With auto-increment off, the pointer stays at the same value across any number of data bytes.
- R9: Each data event in a read transfer raises `rd_stb` with `acc_addr` equal to the pointer, and raises no ACK decision and no write strobe.
- R10: A stop or repeated start keeps the command register, so a later read with no command uses the stored, possibly advanced, pointer.
- R11: Outputs change only one cycle after a data event. Address events, stop events, data events outside a transfer, and unused kind code 3 raise no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte event present this cycle |
| in_kind | input | 2 | Event kind: 0 address, 1 data byte, 2 stop, 3 unused |
| in_rnw | input | 1 | Direction on an address event: 1 read, 0 write |
| in_data | input | 8 | Received byte on a write-direction data event |
| ack_valid | output | 1 | An ACK/NACK decision is presented |
| ack | output | 1 | 1 ACK, 0 NACK, meaningful with ack_valid |
| wr_stb | output | 1 | Write strobe toward the register file |
| rd_stb | output | 1 | Read strobe toward the register file |
| acc_addr | output | 6 | Register address for the strobe |
| wr_data | output | 8 | Write data for the strobe |

## Verification
The bound checker checks on every cycle the rules that involve no transfer history. Read and write strobes never occur together. A write strobe always comes with an ACK and never targets an input register. A read strobe never comes with an ACK decision. Every output follows a data event. The stored command stays legal. With auto-increment off, a data byte never changes the stored command. Only the bench scenarios can show the exact ACK decision for each of the 128 codes, the pointer order including both wrap rules, and the retained pointer across stops and repeated starts.

// File: rtl/i2cptr_pkg.sv
package i2cptr_pkg;
  typedef enum logic [1:0] {
    EV_ADDR = 2'd0,
    EV_DATA = 2'd1,
    EV_STOP = 2'd2
  } ev_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_WDATA,
    PH_RDATA,
    PH_DEAD
  } phase_e;

  typedef enum logic [1:0] {
    RC_NONE,
    RC_RO,
    RC_RW
  } reg_class_e;
endpackage

// File: rtl/i2cptr_classify.sv
module i2cptr_classify
  import i2cptr_pkg::*;
#(
  parameter int CODE_W       = 7,
  parameter int BANK_CNT     = 5,
  parameter int GROUP_CNT    = 5,
  parameter int GROUP_STRIDE = 8,
  parameter int SINGLE_CNT   = 3
) (
  input  logic [CODE_W-1:0] code,
  output reg_class_e        cls
);
  localparam int CODE_CNT    = 2 ** CODE_W;
  localparam int SINGLE_BASE = GROUP_CNT * GROUP_STRIDE;

  function automatic logic code_ok(int c);
    if (c < SINGLE_BASE) return (c % GROUP_STRIDE) < BANK_CNT;
    return c < SINGLE_BASE + SINGLE_CNT;
  endfunction

  logic [CODE_CNT-1:0] legal_vec;
  logic [CODE_CNT-1:0] ro_vec;

  for (genvar c = 0; c < CODE_CNT; c++) begin : g_code
    assign legal_vec[c] = code_ok(c);
    assign ro_vec[c]    = (c < BANK_CNT);
  end

  always_comb begin
    if (!legal_vec[code])  cls = RC_NONE;
    else if (ro_vec[code]) cls = RC_RO;
    else                   cls = RC_RW;
  end
endmodule

// File: rtl/i2cptr_step.sv
module i2cptr_step #(
  parameter int PTR_W        = 6,
  parameter int BANK_CNT     = 5,
  parameter int GROUP_CNT    = 5,
  parameter int GROUP_STRIDE = 8,
  parameter int SINGLE_CNT   = 3
) (
  input  logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] nxt
);
  localparam int OFF_W = $clog2(GROUP_STRIDE);
  localparam logic [PTR_W-1:0] S_BASE = PTR_W'(GROUP_CNT * GROUP_STRIDE);
  localparam logic [PTR_W-1:0] S_LAST = PTR_W'(GROUP_CNT * GROUP_STRIDE + SINGLE_CNT - 1);
  localparam logic [OFF_W-1:0] B_LAST = OFF_W'(BANK_CNT - 1);

  always_comb begin
    if (ptr < S_BASE) begin
      if (ptr[OFF_W-1:0] == B_LAST) nxt = {ptr[PTR_W-1:OFF_W], {OFF_W{1'b0}}};
      else                          nxt = ptr + PTR_W'(1);
    end else if (ptr == S_LAST) begin
      nxt = S_BASE;
    end else begin
      nxt = ptr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/i2cptr_ctrl.sv
module i2cptr_ctrl
  import i2cptr_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_kind,
  input  logic             in_rnw,
  input  logic [CMD_W-1:0] in_data,
  input  reg_class_e       cmd_cls,
  input  reg_class_e       ptr_cls,
  input  logic [PTR_W-1:0] ptr_nxt,
  output logic [CMD_W-1:0] cmd_q,
  output logic             ack_valid,
  output logic             ack,
  output logic             wr_stb,
  output logic             rd_stb,
  output logic [PTR_W-1:0] acc_addr,
  output logic [CMD_W-1:0] wr_data
);
  localparam logic [CMD_W-1:0] CMD_RESET = CMD_W'(1) << (CMD_W - 1);

  phase_e           phase_q, phase_d;
  logic [CMD_W-1:0] cmd_d;
  logic             ackv_d, ack_d, wr_d, rd_d;
  logic [PTR_W-1:0] addr_d;
  logic [CMD_W-1:0] data_d;
  logic             ai;
  logic [PTR_W-1:0] ptr;

  assign ai  = cmd_q[CMD_W-1];
  assign ptr = cmd_q[PTR_W-1:0];

  always_comb begin
    phase_d = phase_q;
    cmd_d   = cmd_q;
    ackv_d  = 1'b0;
    ack_d   = 1'b0;
    wr_d    = 1'b0;
    rd_d    = 1'b0;
    addr_d  = acc_addr;
    data_d  = wr_data;
    if (in_valid) begin
      case (in_kind)
        EV_ADDR: phase_d = in_rnw ? PH_RDATA : PH_CMD;
        EV_STOP: phase_d = PH_IDLE;
        EV_DATA: begin
          case (phase_q)
            PH_CMD: begin
              ackv_d = 1'b1;
              if (cmd_cls != RC_NONE) begin
                ack_d   = 1'b1;
                cmd_d   = in_data;
                phase_d = PH_WDATA;
              end else begin
                phase_d = PH_DEAD;
              end
            end
            PH_WDATA: begin
              ackv_d = 1'b1;
              addr_d = ptr;
              if (ptr_cls == RC_RW) begin
                ack_d  = 1'b1;
                wr_d   = 1'b1;
                data_d = in_data;
              end
              if (ai) cmd_d[PTR_W-1:0] = ptr_nxt;
            end
            PH_RDATA: begin
              rd_d   = 1'b1;
              addr_d = ptr;
              if (ai) cmd_d[PTR_W-1:0] = ptr_nxt;
            end
            PH_DEAD: ackv_d = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cmd_q     <= CMD_RESET;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      wr_stb    <= 1'b0;
      rd_stb    <= 1'b0;
      acc_addr  <= '0;
      wr_data   <= '0;
    end else begin
      phase_q   <= phase_d;
      cmd_q     <= cmd_d;
      ack_valid <= ackv_d;
      ack       <= ack_d;
      wr_stb    <= wr_d;
      rd_stb    <= rd_d;
      acc_addr  <= addr_d;
      wr_data   <= data_d;
    end
  end
endmodule

// File: rtl/i2c_cmd_pointer.sv
module i2c_cmd_pointer
  import i2cptr_pkg::*;
#(
  parameter int CMD_W        = 8,
  parameter int PTR_W        = 6,
  parameter int BANK_CNT     = 5,
  parameter int GROUP_CNT    = 5,
  parameter int GROUP_STRIDE = 8,
  parameter int SINGLE_CNT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_kind,
  input  logic             in_rnw,
  input  logic [CMD_W-1:0] in_data,
  output logic             ack_valid,
  output logic             ack,
  output logic             wr_stb,
  output logic             rd_stb,
  output logic [PTR_W-1:0] acc_addr,
  output logic [CMD_W-1:0] wr_data
);
  localparam int CODE_W = CMD_W - 1;

  logic [CMD_W-1:0] cmd_q;
  logic [PTR_W-1:0] ptr_nxt;
  reg_class_e       cmd_cls, ptr_cls;

  i2cptr_classify #(
    .CODE_W(CODE_W), .BANK_CNT(BANK_CNT), .GROUP_CNT(GROUP_CNT),
    .GROUP_STRIDE(GROUP_STRIDE), .SINGLE_CNT(SINGLE_CNT)
  ) u_cls_cmd (
    .code(in_data[CODE_W-1:0]),
    .cls (cmd_cls)
  );

  i2cptr_classify #(
    .CODE_W(CODE_W), .BANK_CNT(BANK_CNT), .GROUP_CNT(GROUP_CNT),
    .GROUP_STRIDE(GROUP_STRIDE), .SINGLE_CNT(SINGLE_CNT)
  ) u_cls_ptr (
    .code(CODE_W'(cmd_q[PTR_W-1:0])),
    .cls (ptr_cls)
  );

  i2cptr_step #(
    .PTR_W(PTR_W), .BANK_CNT(BANK_CNT), .GROUP_CNT(GROUP_CNT),
    .GROUP_STRIDE(GROUP_STRIDE), .SINGLE_CNT(SINGLE_CNT)
  ) u_step (
    .ptr(cmd_q[PTR_W-1:0]),
    .nxt(ptr_nxt)
  );

  i2cptr_ctrl #(.CMD_W(CMD_W), .PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_kind  (in_kind),
    .in_rnw   (in_rnw),
    .in_data  (in_data),
    .cmd_cls  (cmd_cls),
    .ptr_cls  (ptr_cls),
    .ptr_nxt  (ptr_nxt),
    .cmd_q    (cmd_q),
    .ack_valid(ack_valid),
    .ack      (ack),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .acc_addr (acc_addr),
    .wr_data  (wr_data)
  );
endmodule

// File: rtl/i2cptr_checker.sv
module i2cptr_checker #(
  parameter int CMD_W        = 8,
  parameter int PTR_W        = 6,
  parameter int BANK_CNT     = 5,
  parameter int GROUP_CNT    = 5,
  parameter int GROUP_STRIDE = 8,
  parameter int SINGLE_CNT   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_kind,
  input logic             ack_valid,
  input logic             ack,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic [PTR_W-1:0] acc_addr,
  input logic [CMD_W-1:0] cmd_q
);
  localparam int SINGLE_BASE = GROUP_CNT * GROUP_STRIDE;

  function automatic logic legal_code(int c);
    if (c < SINGLE_BASE) return (c % GROUP_STRIDE) < BANK_CNT;
    return c < SINGLE_BASE + SINGLE_CNT;
  endfunction

  // R9: the two strobes are exclusive
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb));

  // R9: read strobes carry no ACK decision
  p_rd_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !ack_valid);

  // R5: a write strobe is always ACKed
  p_wr_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ack_valid && ack));

  // R6: input registers are never written
  p_ro_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (int'(acc_addr) >= BANK_CNT));

  // R11: any output follows a data event one cycle earlier
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_stb || ack_valid) |-> ($past(in_valid) && $past(in_kind) == 2'd1));

  // R2: the stored command is always a legal code
  p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    legal_code(int'(cmd_q[CMD_W-2:0])));

  // R8: a data byte leaves the pointer alone when auto-increment is off
  p_ai_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !$past(cmd_q[CMD_W-1])) |-> $stable(cmd_q));
endmodule

bind i2c_cmd_pointer i2cptr_checker #(
  .CMD_W(CMD_W), .PTR_W(PTR_W), .BANK_CNT(BANK_CNT), .GROUP_CNT(GROUP_CNT),
  .GROUP_STRIDE(GROUP_STRIDE), .SINGLE_CNT(SINGLE_CNT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_kind  (in_kind),
  .ack_valid(ack_valid),
  .ack      (ack),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb),
  .acc_addr (acc_addr),
  .cmd_q    (cmd_q)
);

// File: tb/i2c_cmd_pointer_tb_top.sv
module i2c_cmd_pointer_tb_top;
  localparam logic [1:0] K_ADDR = 2'd0;
  localparam logic [1:0] K_DATA = 2'd1;
  localparam logic [1:0] K_STOP = 2'd2;
  localparam logic [1:0] K_NONE = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_kind = 2'd0;
  logic       in_rnw = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       ack_valid, ack, wr_stb, rd_stb;
  logic [5:0] acc_addr;
  logic [7:0] wr_data;

  always #10 clk = ~clk;  // 50 MHz

  i2c_cmd_pointer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_rnw(in_rnw), .in_data(in_data), .ack_valid(ack_valid), .ack(ack),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .acc_addr(acc_addr), .wr_data(wr_data)
  );

  typedef struct packed {
    logic       ackv;
    logic       ack;
    logic       wr;
    logic       rd;
    logic [5:0] addr;
    logic [7:0] data;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // requirement model: command register and transfer phase
  logic [7:0] m_cmd = 8'h80;  // R1 reset value
  int         m_ph = 0;       // 0 idle, 1 command, 2 write, 3 read, 4 rejected

  function automatic bit m_legal(int c);
    if (c < 40) return (c % 8) < 5;
    return c < 43;
  endfunction

  function automatic logic [5:0] m_next(logic [5:0] p);
    if (p < 6'd40) return (p[2:0] == 3'd4) ? {p[5:3], 3'd0} : p + 6'd1;
    return (p == 6'd42) ? 6'd40 : p + 6'd1;
  endfunction

  task automatic drive(input bit v, input logic [1:0] k, input bit rnw,
                       input logic [7:0] d, input string req);
    exp_t e;
    e = '0;
    @(negedge clk);
    in_valid = v;
    in_kind  = k;
    in_rnw   = rnw;
    in_data  = d;
    if (v) begin
      case (k)
        K_ADDR: m_ph = rnw ? 3 : 1;
        K_STOP: m_ph = 0;
        K_DATA: begin
          case (m_ph)
            1: begin
              e.ackv = 1'b1;
              if (m_legal(int'(d[6:0]))) begin
                e.ack = 1'b1;
                m_cmd = d;
                m_ph  = 2;
              end else m_ph = 4;
            end
            2: begin
              e.ackv = 1'b1;
              e.addr = m_cmd[5:0];
              if (m_cmd[5:0] >= 6'd5) begin
                e.ack = 1'b1; e.wr = 1'b1; e.data = d;
              end
              if (m_cmd[7]) m_cmd[5:0] = m_next(m_cmd[5:0]);
            end
            3: begin
              e.rd   = 1'b1;
              e.addr = m_cmd[5:0];
              if (m_cmd[7]) m_cmd[5:0] = m_next(m_cmd[5:0]);
            end
            4: e.ackv = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) drive(1'b0, K_NONE, 1'b0, 8'h00, req);
  endtask

  task automatic write_xfer(input logic [7:0] cmd, input int nbytes,
                            input logic [7:0] seed, input string req);
    drive(1'b1, K_ADDR, 1'b0, 8'h00, req);
    drive(1'b1, K_DATA, 1'b0, cmd, req);
    for (int i = 0; i < nbytes; i++) drive(1'b1, K_DATA, 1'b0, seed + 8'(i * 17), req);
  endtask

  task automatic read_xfer(input int nbytes, input string req);
    drive(1'b1, K_ADDR, 1'b1, 8'h00, req);
    for (int i = 0; i < nbytes; i++) drive(1'b1, K_DATA, 1'b0, 8'h00, req);
  endtask

  task automatic stop(input string req);
    drive(1'b1, K_STOP, 1'b0, 8'h00, req);
  endtask

  // monitor: pop one expected item per cycle, compare away from the edge
  always @(posedge clk) begin
    exp_t  e;
    string r;
    bit    bad;
    #5;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      r = req_q.pop_front();
      bad = (ack_valid !== e.ackv) || (wr_stb !== e.wr) || (rd_stb !== e.rd) ||
            (e.ackv && ack !== e.ack) ||
            ((e.wr || e.rd) && acc_addr !== e.addr) ||
            (e.wr && wr_data !== e.data);
      n_chk++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s: got ackv=%0b ack=%0b wr=%0b rd=%0b addr=%02h data=%02h exp ackv=%0b ack=%0b wr=%0b rd=%0b addr=%02h data=%02h",
                 r, ack_valid, ack, wr_stb, rd_stb, acc_addr, wr_data,
                 e.ackv, e.ack, e.wr, e.rd, e.addr, e.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog expired: got running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: outputs quiet while reset is held
    n_chk++;
    if (ack_valid !== 1'b0 || wr_stb !== 1'b0 || rd_stb !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: got ackv=%0b wr=%0b rd=%0b exp 0 0 0", ack_valid, wr_stb, rd_stb);
    end
    rst_n = 1'b1;

    // R1: read without a command uses reset pointer 0 with auto-increment
    read_xfer(3, "R1 reset pointer read");
    stop("R1");

    // R11: events outside a transfer and kind 3 produce nothing
    drive(1'b1, K_DATA, 1'b0, 8'h55, "R11 data while idle");
    drive(1'b1, K_NONE, 1'b0, 8'h55, "R11 unused kind");
    idle(2, "R11 idle");

    // R2, R4: sweep all 128 low-7-bit codes, bit 7 alternating
    for (int c = 0; c < 128; c++) begin
      drive(1'b1, K_ADDR, 1'b0, 8'h00, "R2 sweep");
      drive(1'b1, K_DATA, 1'b0, {c[0], c[6:0]}, "R2 sweep command ack");
      stop("R2 sweep");
    end

    // R7, R5: banked wrap inside a group
    write_xfer(8'h8B, 3, 8'hA1, "R7 banked wrap 0B 0C 08");
    stop("R7");

    // R6: input registers NACK, pointer still advances through wrap
    write_xfer(8'h82, 4, 8'h11, "R6 read-only write rejected");
    stop("R6");

    // R8, R10: auto-increment off holds pointer, repeated start keeps it
    write_xfer(8'h29, 3, 8'h3C, "R8 pointer fixed with AI off");
    read_xfer(2, "R10 repeated start keeps pointer");
    stop("R10");

    // R7: singles wrap 2A -> 28, then a read continues from 29
    write_xfer(8'hAA, 2, 8'h70, "R7 single wrap 2A 28");
    read_xfer(1, "R10 read after stop uses advanced pointer");
    stop("R10");

    // R3: NACKed command keeps prior command, later bytes NACKed
    write_xfer(8'h8C, 0, 8'h00, "R4 load command 8C");
    stop("R4");
    write_xfer(8'h45, 2, 8'h99, "R3 rejected command and following bytes");
    stop("R3");
    read_xfer(2, "R3 prior pointer kept after rejected command");
    stop("R3");

    // R9: longer read with auto-increment across a group boundary
    write_xfer(8'h93, 0, 8'h00, "R9 load command 93");
    read_xfer(4, "R9 read strobes 13 14 10 11");
    stop("R9");

    idle(3, "R11 drain");
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule